// File: doc/BRIEF.md
# Tightly coupled memory region decoder

This block sits in front of a processor's data port and decides, for every load or store, whether the address belongs to the on-chip instruction-side local RAM, the on-chip data-side local RAM, or the external bus. It holds three configuration words: a data-region setting, an instruction-region setting and a control word with one enable bit per region. From these it derives, without any extra write, a compare mask and a base for the data region and a size limit for the instruction region.

The data-region test is a masked equality compare against a base aligned to the region size, not a range check. The RAM index is taken straight from the low address bits, so each physical array repeats across any region larger than itself. Byte, halfword and word accesses are served from both arrays with byte-lane enables. Each hit updates a running access-cycle count that a sequential access extends by one and a non-sequential access restarts at one.

Top module: `tcm_decoder`

## Requirements
- R1: A write with `cfg_sel`=0 stores only the data-region setting bits under 0xFFFFF03E. Reading with `cfg_sel`=0 returns those bits and zero everywhere else.
- R2: A write with `cfg_sel`=1 stores only bits 5:1 of the instruction-region setting. A write with `cfg_sel`=2 stores only control bits 16 (data-region enable) and 18 (instruction-region enable). Any other bit reads back as zero.
- R3: With the data region enabled, its size is 512 shifted left by setting bits 5:1. Its mask is 0xFFFFF000 AND NOT(size-1) and its base is setting AND mask. An access hits the data region when (address AND mask) equals the base, so low setting bits below the size never shift the region.
- R4: When control bit 16 is clear, the data base is all ones and the mask is zero, so no address hits the data region. After reset, every address goes to the external bus.
- R5: With control bit 18 set, an address below 512 shifted left by instruction setting bits 5:1 hits the instruction region. This test wins over a data-region hit at the same address.
- R6: The data RAM index is the address modulo `DTCM_BYTES` and the instruction RAM index is the address modulo `ITCM_BYTES`, with no base subtracted. The arrays mirror inside their regions.
- R7: `acc_size` 0 is a byte, 1 a halfword and 2 a word. A byte store writes `acc_wdata[7:0]` to lane `addr[1:0]`. A halfword store writes `acc_wdata[15:0]` to lanes selected by `addr[1]`. A word store writes all four lanes. Other lanes keep their contents.
- R8: A read returns the addressed byte or halfword zero-extended to 32 bits, or the whole word. `rsp_rdata` is zero for writes and for external accesses.
- R9: Each access gives exactly one response with `rsp_valid` high in the next cycle. `rsp_target` is 0 for external, 1 for the instruction region and 2 for the data region.
- R10: On a region hit, `acc_cycles` becomes 1 when `acc_seq` is low and its previous value plus one when `acc_seq` is high. An external access leaves it unchanged.
- R11: A configuration or control write takes effect for an access presented in the very next cycle.
- R12: After reset, all three configuration words read zero, `acc_cycles` is zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 data setting, 1 instruction setting, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the word chosen by `cfg_sel` |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 store, 0 load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_seq | input | 1 | Access is sequential to the previous one |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 32 | Store data, low-aligned |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_target | output | 2 | 0 external, 1 instruction region, 2 data region |
| rsp_rdata | output | 32 | Load data, zero-extended |
| acc_cycles | output | CYC_W | Running access-cycle count |

## Verification
A wrong mask or base shows at the ports one cycle after the first access near a region edge, as a `rsp_target` of 0 where 2 was due or the reverse. The tests probe just inside and just outside each edge, and use a base whose low bits lie below the region size. A wrong index or lane enable stays hidden until a later load from a mirror alias or a neighbouring lane returns data that differs from the byte-level model. The cycle count is compared on every response, so a wrong seq/non-seq choice shows on the same response.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    TGT_EXT  = 2'd0,
    TGT_ITCM = 2'd1,
    TGT_DTCM = 2'd2
  } tgt_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] CSEL_DSET = 2'd0;
  localparam logic [1:0] CSEL_ISET = 2'd1;
  localparam logic [1:0] CSEL_CTRL = 2'd2;

  localparam logic [31:0] DSET_KEEP = 32'hFFFF_F03E;
  localparam logic [31:0] ISET_KEEP = 32'h0000_003E;
  localparam int          DEN_BIT   = 16;
  localparam int          IEN_BIT   = 18;
  localparam logic [31:0] CTRL_KEEP = (32'd1 << DEN_BIT) | (32'd1 << IEN_BIT);

  localparam logic [31:0] MIN_REGION  = 32'd512;
  localparam logic [31:0] DMASK_FLOOR = 32'hFFFF_F000;

endpackage

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs
  import tcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [31:0] dtcm_base,
  output logic [31:0] dtcm_mask,
  output logic        dtcm_en,
  output logic        itcm_en,
  output logic [4:0]  itcm_field
);

  logic [31:0] dset_q, iset_q, ctrl_q;
  logic        dset_en, iset_en, ctrl_en;
  logic [31:0] dsize, dmask_raw;

  // write enables
  always_comb begin
    dset_en = cfg_we && (cfg_sel == CSEL_DSET);
    iset_en = cfg_we && (cfg_sel == CSEL_ISET);
    ctrl_en = cfg_we && (cfg_sel == CSEL_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dset_q <= '0;
      iset_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (dset_en) dset_q <= cfg_wdata & DSET_KEEP;
      if (iset_en) iset_q <= cfg_wdata & ISET_KEEP;
      if (ctrl_en) ctrl_q <= cfg_wdata & CTRL_KEEP;
    end
  end

  always_comb begin
    case (cfg_sel)
      CSEL_DSET: cfg_rdata = dset_q;
      CSEL_ISET: cfg_rdata = iset_q;
      CSEL_CTRL: cfg_rdata = ctrl_q;
      default:   cfg_rdata = '0;
    endcase
  end

  // region derivation from the stored words
  always_comb begin
    dtcm_en   = ctrl_q[DEN_BIT];
    itcm_en   = ctrl_q[IEN_BIT];
    itcm_field = iset_q[5:1];
    dsize     = MIN_REGION << dset_q[5:1];
    dmask_raw = DMASK_FLOOR & ~(dsize - 32'd1);
    if (dtcm_en) begin
      dtcm_mask = dmask_raw;
      dtcm_base = dset_q & dmask_raw;
    end else begin
      dtcm_mask = '0;
      dtcm_base = '1;
    end
  end

endmodule

// File: rtl/tcm_region_decode.sv
module tcm_region_decode
  import tcm_pkg::*;
(
  input  logic [31:0] addr,
  input  logic [31:0] dtcm_base,
  input  logic [31:0] dtcm_mask,
  input  logic        itcm_en,
  input  logic [4:0]  itcm_field,
  output tgt_e        tgt
);

  logic [5:0] ishamt;
  logic       itcm_hit, dtcm_hit;

  always_comb begin
    ishamt   = 6'd9 + {1'b0, itcm_field};
    itcm_hit = itcm_en && ((addr >> ishamt) == 32'd0);
    dtcm_hit = (addr & dtcm_mask) == dtcm_base;
    if (itcm_hit)      tgt = TGT_ITCM;
    else if (dtcm_hit) tgt = TGT_DTCM;
    else               tgt = TGT_EXT;
  end

endmodule

// File: rtl/tcm_lane_ram.sv
module tcm_lane_ram #(
  parameter int WORDS = 256,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] mem [WORDS];
  logic [31:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (en && !we) rdata_q <= mem[idx];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/tcm_decoder.sv
module tcm_decoder
  import tcm_pkg::*;
#(
  parameter int DTCM_BYTES = 1024,
  parameter int ITCM_BYTES = 2048,
  parameter int CYC_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic             acc_seq,
  input  logic [31:0]      acc_addr,
  input  logic [31:0]      acc_wdata,
  output logic             rsp_valid,
  output logic [1:0]       rsp_target,
  output logic [31:0]      rsp_rdata,
  output logic [CYC_W-1:0] acc_cycles
);

  localparam int D_WORDS = DTCM_BYTES / 4;
  localparam int I_WORDS = ITCM_BYTES / 4;
  localparam int D_IW    = $clog2(D_WORDS);
  localparam int I_IW    = $clog2(I_WORDS);

  logic [31:0] dtcm_base, dtcm_mask;
  logic        dtcm_en, itcm_en;
  logic [4:0]  itcm_field;
  tgt_e        hit_tgt;

  tcm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dtcm_base(dtcm_base), .dtcm_mask(dtcm_mask), .dtcm_en(dtcm_en),
    .itcm_en(itcm_en), .itcm_field(itcm_field)
  );

  tcm_region_decode u_dec (
    .addr(acc_addr), .dtcm_base(dtcm_base), .dtcm_mask(dtcm_mask),
    .itcm_en(itcm_en), .itcm_field(itcm_field), .tgt(hit_tgt)
  );

  // byte lanes and store data placement
  logic [3:0]  be;
  logic [31:0] wlane;
  always_comb begin
    case (acc_size)
      SZ_BYTE: begin
        be    = 4'b0001 << acc_addr[1:0];
        wlane = {4{acc_wdata[7:0]}};
      end
      SZ_HALF: begin
        be    = acc_addr[1] ? 4'b1100 : 4'b0011;
        wlane = {2{acc_wdata[15:0]}};
      end
      default: begin
        be    = 4'b1111;
        wlane = acc_wdata;
      end
    endcase
  end

  logic        d_sel, i_sel;
  logic [31:0] d_rdata, i_rdata;
  assign d_sel = acc_valid && (hit_tgt == TGT_DTCM);
  assign i_sel = acc_valid && (hit_tgt == TGT_ITCM);

  tcm_lane_ram #(.WORDS(D_WORDS)) u_dram (
    .clk(clk), .en(d_sel), .we(acc_write), .be(be),
    .idx(acc_addr[D_IW+1:2]), .wdata(wlane), .rdata(d_rdata)
  );

  tcm_lane_ram #(.WORDS(I_WORDS)) u_iram (
    .clk(clk), .en(i_sel), .we(acc_write), .be(be),
    .idx(acc_addr[I_IW+1:2]), .wdata(wlane), .rdata(i_rdata)
  );

  // response and cycle-count state
  logic             rv_q, rv_n, rd_q, rd_n;
  tgt_e             rt_q, rt_n;
  logic [1:0]       rs_q, rs_n, rl_q, rl_n;
  logic [CYC_W-1:0] cyc_q, cyc_n;

  always_comb begin
    rv_n  = acc_valid;
    rd_n  = acc_valid && !acc_write;
    rt_n  = acc_valid ? hit_tgt : TGT_EXT;
    rs_n  = acc_size;
    rl_n  = acc_addr[1:0];
    cyc_n = cyc_q;
    if (acc_valid && (hit_tgt != TGT_EXT)) begin
      cyc_n = acc_seq ? cyc_q + CYC_W'(1) : CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      rd_q  <= 1'b0;
      rt_q  <= TGT_EXT;
      rs_q  <= '0;
      rl_q  <= '0;
      cyc_q <= '0;
    end else begin
      rv_q  <= rv_n;
      rd_q  <= rd_n;
      rt_q  <= rt_n;
      rs_q  <= rs_n;
      rl_q  <= rl_n;
      cyc_q <= cyc_n;
    end
  end

  // load data alignment
  logic [31:0] raw, sh_b, sh_h, fmt;
  always_comb begin
    case (rt_q)
      TGT_ITCM: raw = i_rdata;
      TGT_DTCM: raw = d_rdata;
      default:  raw = '0;
    endcase
    sh_b = raw >> {rl_q, 3'b000};
    sh_h = raw >> {rl_q[1], 4'b0000};
    case (rs_q)
      SZ_BYTE: fmt = {24'd0, sh_b[7:0]};
      SZ_HALF: fmt = {16'd0, sh_h[15:0]};
      default: fmt = raw;
    endcase
  end

  assign rsp_valid  = rv_q;
  assign rsp_target = rt_q;
  assign rsp_rdata  = (rv_q && rd_q) ? fmt : 32'd0;
  assign acc_cycles = cyc_q;

endmodule

// File: rtl/tcm_decoder_chk.sv
module tcm_decoder_chk #(
  parameter int CYC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_seq,
  input logic [1:0]       cfg_sel,
  input logic [31:0]      cfg_rdata,
  input logic             rsp_valid,
  input logic [1:0]       rsp_target,
  input logic [31:0]      rsp_rdata,
  input logic [CYC_W-1:0] acc_cycles,
  input logic             den
);

  p_dset_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd0) |-> ((cfg_rdata & ~32'hFFFF_F03E) == 32'd0));

  p_iset_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd1) |-> ((cfg_rdata & ~32'h0000_003E) == 32'd0));

  p_dtcm_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == 2'd2) |-> $past(den));

  p_ext_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == 2'd0) |-> (rsp_rdata == 32'd0));

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  p_no_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  p_seq_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target != 2'd0 && $past(acc_seq))
      |-> (acc_cycles == $past(acc_cycles) + CYC_W'(1)));

  p_nonseq_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target != 2'd0 && !$past(acc_seq))
      |-> (acc_cycles == CYC_W'(1)));

  p_ext_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == 2'd0) |-> $stable(acc_cycles));

endmodule

bind tcm_decoder tcm_decoder_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_seq(acc_seq),
  .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid),
  .rsp_target(rsp_target), .rsp_rdata(rsp_rdata), .acc_cycles(acc_cycles),
  .den(dtcm_en)
);

// File: tb/tb_tcm_decoder.sv
module tb_tcm_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int DB = 1024;
  localparam int IB = 2048;
  localparam int CW = 8;

  logic          clk, rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic          acc_valid, acc_write, acc_seq;
  logic [1:0]    acc_size;
  logic [31:0]   acc_addr, acc_wdata;
  logic          rsp_valid;
  logic [1:0]    rsp_target;
  logic [31:0]   rsp_rdata;
  logic [CW-1:0] acc_cycles;

  tcm_decoder #(.DTCM_BYTES(DB), .ITCM_BYTES(IB), .CYC_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_size(acc_size), .acc_seq(acc_seq),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_rdata(rsp_rdata), .acc_cycles(acc_cycles)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [1:0]    tgt;
    logic [31:0]   data;
    logic [CW-1:0] cyc;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // bench-side model state
  logic [31:0]   m_dset, m_iset, m_ctrl;
  logic [CW-1:0] m_cyc;
  logic [7:0]    dm [int];
  logic [7:0]    im [int];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] m_target(input logic [31:0] a);
    logic [63:0] isz, dsz;
    logic [31:0] msk, base;
    isz  = 64'd512 << m_iset[5:1];
    dsz  = 64'd512 << m_dset[5:1];
    msk  = 32'hFFFF_F000 & ~(dsz[31:0] - 32'd1);
    base = m_dset & msk;
    if (m_ctrl[18] && ({32'd0, a} < isz)) return 2'd1;
    if (m_ctrl[16] && ((a & msk) == base)) return 2'd2;
    return 2'd0;
  endfunction

  task automatic do_cfg(input logic [1:0] sel, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 0; cfg_we = 1; cfg_sel = sel; cfg_wdata = wd;
    case (sel)
      2'd0: m_dset = wd & 32'hFFFF_F03E;
      2'd1: m_iset = wd & 32'h0000_003E;
      2'd2: m_ctrl = wd & 32'h0005_0000;
      default: ;
    endcase
  endtask

  task automatic chk_cfg(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    acc_valid = 0; cfg_we = 0; cfg_sel = sel;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic do_acc(input bit wr, input logic [1:0] sz, input bit sq,
                        input logic [31:0] a, input logic [31:0] wd, input string tag);
    exp_t e;
    int nb;
    logic [31:0] al;
    @(negedge clk);
    cfg_we = 0; acc_valid = 1; acc_write = wr; acc_size = sz; acc_seq = sq;
    acc_addr = a; acc_wdata = wd;
    e.tgt = m_target(a); e.data = 32'd0; e.tag = tag;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    al = (sz == 2'd0) ? a : (sz == 2'd1) ? (a & ~32'd1) : (a & ~32'd3);
    if (e.tgt != 2'd0) begin
      m_cyc = sq ? m_cyc + CW'(1) : CW'(1);
      for (int k = 0; k < nb; k++) begin
        int di, ii;
        di = int'((al + 32'(k)) & 32'(DB - 1));
        ii = int'((al + 32'(k)) & 32'(IB - 1));
        if (wr) begin
          if (e.tgt == 2'd2) dm[di] = wd[8*k +: 8];
          else               im[ii] = wd[8*k +: 8];
        end else begin
          e.data[8*k +: 8] = (e.tgt == 2'd2) ? dm[di] : im[ii];
        end
      end
    end
    e.cyc = m_cyc;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; cfg_we = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      if (sbq.size() == 0) begin
        check("R9 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " target"}, {30'd0, rsp_target}, {30'd0, e.tgt});
        check({e.tag, " data"}, rsp_rdata, e.data);
        check({e.tag, " R10 cycles"}, 32'(acc_cycles), 32'(e.cyc));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_valid = 0; acc_write = 0; acc_size = 0; acc_seq = 0;
    acc_addr = 0; acc_wdata = 0;
    m_dset = 0; m_iset = 0; m_ctrl = 0; m_cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R12 reset state
    check("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R12 acc_cycles after reset", 32'(acc_cycles), 32'd0);
    chk_cfg(2'd0, 32'd0, "R12 data setting reset");
    chk_cfg(2'd1, 32'd0, "R12 instr setting reset");
    chk_cfg(2'd2, 32'd0, "R12 control reset");

    // R4 nothing hits after reset
    do_acc(0, 2'd2, 0, 32'h0000_0000, 0, "R4 reset addr 0");
    do_acc(0, 2'd2, 0, 32'hFFFF_FFFC, 0, "R4 reset addr top");
    idle();

    // R1 R2 keep masks
    do_cfg(2'd0, 32'hFFFF_FFFF);
    chk_cfg(2'd0, 32'hFFFF_F03E, "R1 data setting keep");
    do_cfg(2'd1, 32'hFFFF_FFFF);
    chk_cfg(2'd1, 32'h0000_003E, "R2 instr setting keep");
    do_cfg(2'd2, 32'hFFFF_FFFF);
    chk_cfg(2'd2, 32'h0005_0000, "R2 control keep");

    // R3 R11: base with low bits under the size; access right after write
    do_cfg(2'd1, 32'h0000_0000);
    do_cfg(2'd0, 32'h0080_100A);
    do_acc(1, 2'd2, 0, 32'h0080_0010, 32'h1122_3344, "R11 R3 first access after cfg");
    // R7 lanes
    do_acc(1, 2'd0, 0, 32'h0080_0011, 32'h0000_00AA, "R7 byte store");
    do_acc(1, 2'd1, 0, 32'h0080_0012, 32'h0000_BEEF, "R7 half store");
    do_acc(0, 2'd2, 0, 32'h0080_0010, 0, "R7 word after lane stores");
    // R8 narrow loads
    do_acc(0, 2'd0, 0, 32'h0080_0013, 0, "R8 byte load lane3");
    do_acc(0, 2'd0, 0, 32'h0080_0011, 0, "R8 byte load lane1");
    do_acc(0, 2'd1, 0, 32'h0080_0010, 0, "R8 half load low");
    do_acc(0, 2'd1, 0, 32'h0080_0012, 0, "R8 half load high");
    // R3 edges
    do_acc(1, 2'd2, 0, 32'h0080_3FFC, 32'hCAFE_F00D, "R3 last word in region");
    do_acc(0, 2'd2, 0, 32'h0080_3FFC, 0, "R3 read last word");
    do_acc(0, 2'd2, 0, 32'h0080_4000, 0, "R3 just above region");
    do_acc(0, 2'd2, 0, 32'h007F_FFFC, 0, "R3 just below region");
    do_acc(1, 2'd2, 0, 32'h0080_4000, 32'h1234_5678, "R8 external store");
    // R6 mirrors
    do_acc(0, 2'd2, 0, 32'h0080_0410, 0, "R6 mirror one array up");
    do_acc(0, 2'd2, 0, 32'h0080_3C10, 0, "R6 mirror far");

    // R5 instruction region and priority
    do_acc(1, 2'd2, 0, 32'h0000_01FC, 32'h5A5A_A5A5, "R5 instr last word");
    do_acc(0, 2'd2, 0, 32'h0000_01FC, 0, "R5 instr read");
    do_acc(0, 2'd2, 0, 32'h0000_0200, 0, "R5 instr edge external");
    do_cfg(2'd0, 32'h0000_0000);
    do_acc(1, 2'd2, 0, 32'h0000_0100, 32'h0102_0304, "R5 overlap goes instr");
    do_acc(1, 2'd2, 0, 32'h0000_0300, 32'h0A0B_0C0D, "R5 data part of overlap");
    do_acc(0, 2'd2, 0, 32'h0000_0100, 0, "R5 overlap read instr");
    do_acc(0, 2'd2, 0, 32'h0000_0FFC, 0, "R6 data mirror at 0xFFC");
    do_acc(0, 2'd2, 0, 32'h0000_1000, 0, "R3 above 4K region");

    // R10 cycle count
    do_acc(0, 2'd2, 0, 32'h0000_0300, 0, "R10 nonseq hit");
    do_acc(1, 2'd2, 1, 32'h0000_0304, 32'h0000_0001, "R10 seq hit");
    do_acc(1, 2'd2, 1, 32'h0000_0308, 32'h0000_0002, "R10 seq hit again");
    do_acc(0, 2'd2, 1, 32'h0000_1000, 0, "R10 external holds");
    do_acc(0, 2'd2, 1, 32'h0000_0304, 0, "R10 seq after external");
    do_acc(0, 2'd2, 0, 32'h0000_0308, 0, "R10 nonseq restarts");

    // R4 disable data region
    do_cfg(2'd2, 32'h0004_0000);
    do_acc(0, 2'd2, 0, 32'h0000_0300, 0, "R4 data disabled");
    do_acc(0, 2'd2, 0, 32'h0000_0100, 0, "R4 instr still on");
    do_cfg(2'd2, 32'h0000_0000);
    do_acc(0, 2'd2, 0, 32'h0000_0100, 0, "R5 instr disabled");
    idle();
    repeat (3) @(negedge clk);
    check("R9 all responses seen", 32'(sbq.size()), 32'd0);
    finish_run();
  end

endmodule